// File: doc/BRIEF.md
# Multiplexed Parallel Bus Master

This block runs single-byte read and write transfers on an 8-bit parallel bus whose data lines also carry the address. A user request holds a 16-bit address, a direction flag, a target index and a write byte. The master sends the address as two strobed byte phases, low byte first. It then either drives the write byte or releases the data lines for a read. Next it asserts the select of the chosen target and the read or write strobe. It then waits for the target to pull an active-low acknowledge, or for a cycle-count timeout to expire.

When the wait ends, every select and strobe returns to its inactive level in the same cycle. A one-cycle done pulse follows, with an error flag if the wait timed out. A read returns the byte present on the data inputs when the wait ended. Only one transfer is in flight at a time. A request is taken only while the master is idle. Each strobe phase lasts `PHASE_CYC` clocks. The acknowledge passes through `SYNC_STAGES` flops before the sequencer sees it.

Top module: `mux_bus_master`

## Requirements
- R1: After reset, and whenever `busy` is low, `cs_n` is all ones, `rd_n` and `wr_n` are 1, `ale_lo`, `ale_hi` and `bus_d_oe` are 0, and `done` and `err` are 0.
- R2: The first phase of a transfer drives `req_addr[7:0]` on `bus_d_out` with `bus_d_oe` = 1 and `ale_lo` = 1 for `PHASE_CYC` cycles.
- R3: The second phase drives `req_addr[15:8]` with `ale_hi` = 1 for `PHASE_CYC` cycles, immediately after the low phase. The two address strobes are never high together.
- R4: A write drives `req_wdata` on `bus_d_out` with `bus_d_oe` = 1 from the data phase until the end of the wait. A read holds `bus_d_oe` = 0 from the data phase until the end of the wait.
- R5: Target index t pulls only `cs_n[t]` low (t = 0 gives `cs_n` = 2'b10, t = 1 gives 2'b01). The select phase, lasting `PHASE_CYC` cycles, comes before any read or write strobe. No strobe is ever low without a select.
- R6: A read pulls `rd_n` low and a write pulls `wr_n` low, never both.
- R7: With `ack_n` first driven low d cycles into the strobe, the wait ends after d + `SYNC_STAGES` + 1 cycles. `done` then pulses for one cycle with `err` = 0 while all controls are inactive, and `busy` stays high for 4·`PHASE_CYC` + d + `SYNC_STAGES` + 2 cycles in total.
- R8: If no acknowledge arrives within `TIMEOUT_CYC` strobe cycles, `done` pulses with `err` = 1 and `busy` lasts 4·`PHASE_CYC` + `TIMEOUT_CYC` + 1 cycles. The next transfer completes normally.
- R9: `rdata` takes the value of `bus_d_in` from the cycle in which a read's wait ends, whether by acknowledge or timeout. A write leaves `rdata` unchanged.
- R10: `req_valid` while `busy` is high is ignored. The transfer in flight keeps its address, target and direction, and no second transfer starts afterwards.
- R11: `busy` rises on the clock edge that takes a request and stays high through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 16 | Transfer address |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_tgt | input | TGT_W (1) | Target index |
| req_wdata | input | 8 | Write byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Timeout flag, valid with done |
| rdata | output | 8 | Last read result |
| bus_d_out | output | 8 | Data/address lines, outgoing value |
| bus_d_oe | output | 1 | Output enable for data lines |
| bus_d_in | input | 8 | Data lines, incoming value |
| cs_n | output | NUM_CS (2) | Active-low target selects |
| ale_lo | output | 1 | Low address byte strobe |
| ale_hi | output | 1 | High address byte strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| ack_n | input | 1 | Active-low acknowledge from target |

## Verification
A sequencer stuck in, or skipping, a phase shows at the bus pins within one phase. An address strobe would be missing or out of order, or a select would appear without its strobe. A wrong phase or wait counter changes the length of the `busy` window, and the bench measures that window to the exact cycle on every transfer. A corrupted request latch shows up at the strobe phase as a wrong byte, select or direction seen by the target model. A wrong capture point shows up in `rdata` on the `done` cycle.

// File: rtl/mbm_pkg.sv
package mbm_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 16;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ALO,
      ST_AHI,
      ST_DATA,
      ST_SEL,
      ST_WAIT,
      ST_DONE
   } mbm_state_e;

   function automatic logic in_strobe_span(input mbm_state_e s);
      return (s == ST_SEL) || (s == ST_WAIT);
   endfunction
endpackage

// File: rtl/mbm_ack_sync.sv
module mbm_ack_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ack_n_raw,
   output logic ack_n_sync
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign ack_n_sync = ack_n_raw;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-2+((STAGES==1)?1:0):0], ack_n_raw};
         end
         assign ack_n_sync = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/mbm_phase_timer.sv
module mbm_phase_timer #(
   parameter int PHASE_CYC   = 2,
   parameter int TIMEOUT_CYC = 100000,
   localparam int LIMIT      = (PHASE_CYC > TIMEOUT_CYC) ? PHASE_CYC : TIMEOUT_CYC,
   localparam int CNT_W      = $clog2(LIMIT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic phase_end,
   output logic wait_end
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     cnt_q <= '0;
      else if (clr)                   cnt_q <= '0;
      else if (cnt_q != CNT_W'(LIMIT)) cnt_q <= cnt_q + 1'b1;
   end

   assign phase_end = (cnt_q == CNT_W'(PHASE_CYC - 1));
   assign wait_end  = (cnt_q == CNT_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/mbm_seq.sv
module mbm_seq
   import mbm_pkg::*;
#(
   parameter int TGT_W = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  req_rd,
   input  logic [TGT_W-1:0]      req_tgt,
   input  logic [BYTE_W-1:0]     req_wdata,
   input  logic                  ack_n_sync,
   input  logic [BYTE_W-1:0]     bus_d_in,
   input  logic                  phase_end,
   input  logic                  wait_end,
   output logic                  timer_clr,
   output mbm_state_e            state,
   output logic [ADDR_W-1:0]     lat_addr,
   output logic                  lat_rd,
   output logic [TGT_W-1:0]      lat_tgt,
   output logic [BYTE_W-1:0]     lat_wdata,
   output logic [BYTE_W-1:0]     rdata,
   output logic                  timed_out
);
   mbm_state_e state_q, state_d;
   logic       finish;

   assign finish = (state_q == ST_WAIT) && (!ack_n_sync || wait_end);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (req_valid) state_d = ST_ALO;
         ST_ALO:  if (phase_end) state_d = ST_AHI;
         ST_AHI:  if (phase_end) state_d = ST_DATA;
         ST_DATA: if (phase_end) state_d = ST_SEL;
         ST_SEL:  if (phase_end) state_d = ST_WAIT;
         ST_WAIT: if (finish)    state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign timer_clr = (state_d != state_q) || (state_q == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         lat_addr  <= '0;
         lat_rd    <= 1'b0;
         lat_tgt   <= '0;
         lat_wdata <= '0;
         rdata     <= '0;
         timed_out <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && req_valid) begin
            lat_addr  <= req_addr;
            lat_rd    <= req_rd;
            lat_tgt   <= req_tgt;
            lat_wdata <= req_wdata;
         end
         if (finish) begin
            timed_out <= ack_n_sync;
            if (lat_rd) rdata <= bus_d_in;
         end
      end
   end

   assign state = state_q;
endmodule

// File: rtl/mbm_bus_drive.sv
module mbm_bus_drive
   import mbm_pkg::*;
#(
   parameter int NUM_CS = 2,
   parameter int TGT_W  = 1
) (
   input  mbm_state_e            state,
   input  logic [ADDR_W-1:0]     lat_addr,
   input  logic                  lat_rd,
   input  logic [TGT_W-1:0]      lat_tgt,
   input  logic [BYTE_W-1:0]     lat_wdata,
   output logic [BYTE_W-1:0]     bus_d_out,
   output logic                  bus_d_oe,
   output logic [NUM_CS-1:0]     cs_n,
   output logic                  ale_lo,
   output logic                  ale_hi,
   output logic                  rd_n,
   output logic                  wr_n
);
   logic data_span;
   logic sel_span;

   assign data_span = (state == ST_DATA) || in_strobe_span(state);
   assign sel_span  = in_strobe_span(state);

   always_comb begin
      unique case (state)
         ST_ALO:  bus_d_out = lat_addr[BYTE_W-1:0];
         ST_AHI:  bus_d_out = lat_addr[ADDR_W-1:BYTE_W];
         ST_DATA, ST_SEL, ST_WAIT: bus_d_out = lat_wdata;
         default: bus_d_out = '0;
      endcase
   end

   assign bus_d_oe = (state == ST_ALO) || (state == ST_AHI) || (data_span && !lat_rd);
   assign ale_lo   = (state == ST_ALO);
   assign ale_hi   = (state == ST_AHI);
   assign rd_n     = !((state == ST_WAIT) && lat_rd);
   assign wr_n     = !((state == ST_WAIT) && !lat_rd);

   for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
      assign cs_n[i] = !(sel_span && (lat_tgt == TGT_W'(i)));
   end
endmodule

// File: rtl/mux_bus_master.sv
module mux_bus_master
   import mbm_pkg::*;
#(
   parameter int PHASE_CYC   = 2,
   parameter int TIMEOUT_CYC = 100000,
   parameter int SYNC_STAGES = 2,
   parameter int NUM_CS      = 2,
   localparam int TGT_W      = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [15:0]       req_addr,
   input  logic              req_rd,
   input  logic [TGT_W-1:0]  req_tgt,
   input  logic [7:0]        req_wdata,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [7:0]        rdata,
   output logic [7:0]        bus_d_out,
   output logic              bus_d_oe,
   input  logic [7:0]        bus_d_in,
   output logic [NUM_CS-1:0] cs_n,
   output logic              ale_lo,
   output logic              ale_hi,
   output logic              rd_n,
   output logic              wr_n,
   input  logic              ack_n
);
   generate
      if (PHASE_CYC < 1)                       begin : g_bad_phase $error("PHASE_CYC must be at least 1"); end
      if (TIMEOUT_CYC < 1)                     begin : g_bad_to    $error("TIMEOUT_CYC must be at least 1"); end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4)  begin : g_bad_sync  $error("SYNC_STAGES must be 0..4"); end
      if (NUM_CS < 1 || NUM_CS > 8)            begin : g_bad_cs    $error("NUM_CS must be 1..8"); end
   endgenerate

   logic              ack_n_sync;
   logic              phase_end;
   logic              wait_end;
   logic              timer_clr;
   logic              timed_out;
   mbm_state_e        state;
   logic [15:0]       lat_addr;
   logic              lat_rd;
   logic [TGT_W-1:0]  lat_tgt;
   logic [7:0]        lat_wdata;

   mbm_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack_n_raw  (ack_n),
      .ack_n_sync (ack_n_sync)
   );

   mbm_phase_timer #(.PHASE_CYC(PHASE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (timer_clr),
      .phase_end (phase_end),
      .wait_end  (wait_end)
   );

   mbm_seq #(.TGT_W(TGT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_addr   (req_addr),
      .req_rd     (req_rd),
      .req_tgt    (req_tgt),
      .req_wdata  (req_wdata),
      .ack_n_sync (ack_n_sync),
      .bus_d_in   (bus_d_in),
      .phase_end  (phase_end),
      .wait_end   (wait_end),
      .timer_clr  (timer_clr),
      .state      (state),
      .lat_addr   (lat_addr),
      .lat_rd     (lat_rd),
      .lat_tgt    (lat_tgt),
      .lat_wdata  (lat_wdata),
      .rdata      (rdata),
      .timed_out  (timed_out)
   );

   mbm_bus_drive #(.NUM_CS(NUM_CS), .TGT_W(TGT_W)) u_drive (
      .state     (state),
      .lat_addr  (lat_addr),
      .lat_rd    (lat_rd),
      .lat_tgt   (lat_tgt),
      .lat_wdata (lat_wdata),
      .bus_d_out (bus_d_out),
      .bus_d_oe  (bus_d_oe),
      .cs_n      (cs_n),
      .ale_lo    (ale_lo),
      .ale_hi    (ale_hi),
      .rd_n      (rd_n),
      .wr_n      (wr_n)
   );

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_DONE);
   assign err  = done && timed_out;
endmodule

// File: rtl/mbm_checker.sv
module mbm_checker #(
   parameter int NUM_CS = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic              bus_d_oe,
   input logic [NUM_CS-1:0] cs_n,
   input logic              ale_lo,
   input logic              ale_hi,
   input logic              rd_n,
   input logic              wr_n
);
   logic no_sel;
   logic ctrl_quiet;
   logic strobing;

   assign no_sel     = (cs_n == {NUM_CS{1'b1}});
   assign ctrl_quiet = no_sel && rd_n && wr_n && !ale_lo && !ale_hi;
   assign strobing   = !rd_n || !wr_n;

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ctrl_quiet && !bus_d_oe && !done && !err)); // R1
   AST_ALE_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (ale_lo || ale_hi) |-> bus_d_oe); // R2
   AST_ONE_ALE: assert property (@(posedge clk) disable iff (!rst_n)
      !(ale_lo && ale_hi)); // R3
   AST_HI_AFTER_LO: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ale_hi) |-> $past(ale_lo)); // R3
   AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> !bus_d_oe); // R4
   AST_ONE_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~cs_n) <= 1); // R5
   AST_STROBE_HAS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      strobing |-> !no_sel); // R5
   AST_SEL_BEFORE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(rd_n) || $fell(wr_n)) |-> $past(!no_sel)); // R5
   AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n && !wr_n)); // R6
   AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ctrl_quiet); // R7
   AST_DONE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(strobing)); // R7
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done); // R8
   AST_BUSY_FROM_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid)); // R11
   AST_BUSY_ENDS_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(done)); // R11
endmodule

bind mux_bus_master mbm_checker #(.NUM_CS(NUM_CS)) u_mbm_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .bus_d_oe  (bus_d_oe),
   .cs_n      (cs_n),
   .ale_lo    (ale_lo),
   .ale_hi    (ale_hi),
   .rd_n      (rd_n),
   .wr_n      (wr_n)
);

// File: tb/test_mux_bus_master.sv
module test_mux_bus_master;
   localparam int PH   = 2;
   localparam int TO   = 40;
   localparam int SYNC = 2;
   localparam int NCS  = 2;
   localparam int NVEC = 6;

   // {rd, tgt, addr[15:0], wdata[7:0], ack_delay[7:0], read_value[7:0]}
   localparam logic [41:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 16'h1234, 8'hA5, 8'd0,  8'h00},
      {1'b1, 1'b0, 16'hABCD, 8'h00, 8'd2,  8'h3C},
      {1'b0, 1'b1, 16'hFF00, 8'h0F, 8'd5,  8'h00},
      {1'b1, 1'b1, 16'h00FF, 8'h00, 8'd1,  8'hC3},
      {1'b0, 1'b0, 16'h8001, 8'hFF, 8'd10, 8'h00},
      {1'b1, 1'b1, 16'h7E81, 8'h00, 8'd0,  8'h81}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [15:0] req_addr = '0;
   logic       req_rd = 1'b0;
   logic       req_tgt = 1'b0;
   logic [7:0] req_wdata = '0;
   logic       busy, done, err;
   logic [7:0] rdata, bus_d_out;
   logic       bus_d_oe;
   logic [7:0] bus_d_in = '0;
   logic [NCS-1:0] cs_n;
   logic       ale_lo, ale_hi, rd_n, wr_n;
   logic       ack_n = 1'b1;

   int tests = 0;
   int fails = 0;

   // target model state
   int         tgt_delay = 255;
   logic [7:0] tgt_rval = '0;
   int         strobe_cnt = 0;
   logic [7:0] cap_lo, cap_hi, cap_wd;
   logic [NCS-1:0] cap_cs;
   logic       cap_rd, got_lo, order_bad, oe_bad, saw_strobe;

   always #5 clk = ~clk;

   mux_bus_master #(.PHASE_CYC(PH), .TIMEOUT_CYC(TO), .SYNC_STAGES(SYNC), .NUM_CS(NCS)) i_mux_bus_master (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr), .req_rd(req_rd),
      .req_tgt(req_tgt), .req_wdata(req_wdata), .busy(busy), .done(done), .err(err),
      .rdata(rdata), .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
      .cs_n(cs_n), .ale_lo(ale_lo), .ale_hi(ale_hi), .rd_n(rd_n), .wr_n(wr_n), .ack_n(ack_n)
   );

   always @(negedge clk) begin
      if (ale_lo) begin cap_lo = bus_d_out; got_lo = 1'b1; end
      if (ale_hi) begin cap_hi = bus_d_out; if (!got_lo) order_bad = 1'b1; end
      if (!rd_n || !wr_n) begin
         saw_strobe = 1'b1;
         cap_cs = cs_n;
         cap_rd = !rd_n;
         if (!wr_n) begin cap_wd = bus_d_out; if (!bus_d_oe) oe_bad = 1'b1; end
         if (!rd_n && bus_d_oe) oe_bad = 1'b1;
         bus_d_in = tgt_rval;
         if (tgt_delay != 255 && strobe_cnt == tgt_delay) ack_n = 1'b0;
         strobe_cnt++;
      end else begin
         ack_n = 1'b1;
         strobe_cnt = 0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // returns busy length and err at done; optionally fires a second request mid-flight
   task automatic run_txn(input logic rd, input logic tgt, input logic [15:0] addr,
                          input logic [7:0] wd, input int dly, input logic [7:0] rv,
                          input bit intrude, output int blen, output logic err_at_done);
      got_lo = 0; order_bad = 0; oe_bad = 0; saw_strobe = 0;
      cap_lo = 'x; cap_hi = 'x; cap_wd = 'x; cap_cs = 'x; cap_rd = 'x;
      tgt_delay = dly; tgt_rval = rv;
      req_valid = 1'b1; req_rd = rd; req_tgt = tgt; req_addr = addr; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0;
      blen = 0; err_at_done = 0;
      for (int w = 0; w < 2000; w++) begin
         if (busy) blen++;
         if (done) begin err_at_done = err; break; end
         if (intrude && blen == 3) begin
            req_valid = 1'b1; req_rd = ~rd; req_tgt = ~tgt; req_addr = ~addr; req_wdata = ~wd;
         end else begin
            req_valid = 1'b0;
         end
         @(negedge clk);
      end
      req_valid = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      int blen;
      logic e;
      logic [7:0] prev;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cs_n == 2'b11 && rd_n && wr_n && !ale_lo && !ale_hi && !bus_d_oe, "R1", {cs_n, rd_n, wr_n, ale_lo, ale_hi, bus_d_oe}, 7'b1111000);
      chk(!busy && !done && !err, "R1", {busy, done, err}, 0);

      for (int v = 0; v < NVEC; v++) begin
         logic vrd, vtgt;
         logic [15:0] vaddr;
         logic [7:0] vwd, vrv;
         int vd;
         {vrd, vtgt, vaddr, vwd} = VEC[v][41:16];
         vd  = int'(VEC[v][15:8]);
         vrv = VEC[v][7:0];
         prev = rdata;
         run_txn(vrd, vtgt, vaddr, vwd, vd, vrv, 1'b0, blen, e);
         chk(cap_lo == vaddr[7:0], "R2", cap_lo, vaddr[7:0]);
         chk(cap_hi == vaddr[15:8], "R3", cap_hi, vaddr[15:8]);
         chk(!order_bad, "R3", order_bad, 0);
         chk(!oe_bad, "R4", oe_bad, 0);
         chk(cap_cs == ~(2'b01 << vtgt), "R5", cap_cs, ~(2'b01 << vtgt));
         chk(saw_strobe && cap_rd == vrd, "R6", cap_rd, vrd);
         chk(!e, "R7", e, 0);
         chk(blen == 4*PH + vd + SYNC + 2, "R7", blen, 4*PH + vd + SYNC + 2);
         if (vrd) chk(rdata == vrv, "R9", rdata, vrv);
         else begin
            chk(cap_wd == vwd, "R4", cap_wd, vwd);
            chk(rdata == prev, "R9", rdata, prev);
         end
      end

      // R8 timeout on a read, data sampled when it fired
      run_txn(1'b1, 1'b1, 16'h4242, 8'h00, 255, 8'h77, 1'b0, blen, e);
      chk(e, "R8", e, 1);
      chk(blen == 4*PH + TO + 1, "R8", blen, 4*PH + TO + 1);
      chk(rdata == 8'h77, "R9", rdata, 8'h77);
      // recovery after timeout
      run_txn(1'b0, 1'b0, 16'h0102, 8'h55, 3, 8'h00, 1'b0, blen, e);
      chk(!e && cap_wd == 8'h55, "R8", {e, cap_wd}, 9'h055);

      // R10 request while busy is ignored
      prev = rdata;
      run_txn(1'b0, 1'b0, 16'h1357, 8'h24, 1, 8'h00, 1'b1, blen, e);
      chk({cap_hi, cap_lo} == 16'h1357, "R10", {cap_hi, cap_lo}, 16'h1357);
      chk(cap_cs == 2'b10 && cap_rd == 1'b0 && cap_wd == 8'h24, "R10", {cap_cs, cap_rd, cap_wd}, {2'b10, 1'b0, 8'h24});
      chk(blen == 4*PH + 1 + SYNC + 2, "R11", blen, 4*PH + 1 + SYNC + 2);
      for (int k = 0; k < 6; k++) begin
         chk(!busy && cs_n == 2'b11, "R10", {busy, cs_n}, 3'b011);
         @(negedge clk);
      end
      chk(rdata == prev, "R9", rdata, prev);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule